// File: doc/BRIEF.md
# Sub-Block Motion Vector Resolver

This block works out the final motion vector of every 4x4 sub-block in a 16x16 macroblock that has been split into a grid of sixteen sub-blocks. Each sub-block carries a 2-bit code that picks where its vector comes from. It can take a fresh vector from an input stream. It can copy the vector of the sub-block to its left. It can copy the vector of the sub-block above it. Because every sub-block picks its source on its own, partitions of any shape come out of the per-sub-block codes.

A start pulse captures three things: the sixteen codes, the four edge vectors of the macroblock to the left and the four edge vectors of the macroblock above. The block then walks the sub-blocks in raster order, one per clock cycle. It stalls only while a sub-block coded New waits for a vector on the valid/ready input stream. A sub-block in column 0 that copies "left" uses the left-macroblock edge vector for its row. A sub-block in row 0 that copies "above" uses the above-macroblock edge vector for its column. When the sixteenth sub-block is resolved, the block presents all sixteen vectors, raises a one-cycle done pulse and goes back to idle.

Top module: `mv_split_resolver`

## Requirements
- R1: After reset, busy_o, done_o, new_ready_o and err_o are all low.
- R2: A start_i sampled high while idle captures the codes and both edge buses. The walk then resolves sub-blocks k = row*4+col in raster order. With no waiting on the stream, done_o is high exactly 16 clock edges after the edge that sampled start_i.
- R3: Code 0 (copy left), taken from codes_i[2k+1:2k], gives a sub-block in column 1..3 the vector of sub-block k-1. In column 0 it gives left_edge_i[32*row +: 32].
- R4: Code 1 (copy above) gives a sub-block in row 1..3 the vector of sub-block k-4. In row 0 it gives top_edge_i[32*col +: 32].
- R5: Code 2 (new) holds new_ready_o high while that sub-block is current and takes new_mv_i on the first edge where new_valid_i is also high. It consumes exactly one stream vector per New sub-block, in raster order. Each cycle of new_ready_o high with new_valid_i low adds one cycle to the walk.
- R6: A vector is 32 bits: signed x in bits [15:0] and signed y in bits [31:16]. The result for sub-block k appears on mv_o[32k +: 32].
- R7: Code 3 is illegal. It resolves to the zero vector, sets err_o, and lets the walk go on without stalling. err_o stays high until the next accepted start.
- R8: done_o is high for exactly one cycle. busy_o is low from then on, and mv_o does not change while the block is idle.
- R9: A start_i pulse during a walk is ignored, along with any change of codes_i or the edge buses. The running walk finishes on its original inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (accepted only when idle) |
| codes_i | input | 32 | Sixteen 2-bit sub-block codes, sub-block k at bits [2k+1:2k] |
| left_edge_i | input | 128 | Four edge vectors of the left macroblock, one per row |
| top_edge_i | input | 128 | Four edge vectors of the above macroblock, one per column |
| new_mv_i | input | 32 | Stream vector for New sub-blocks |
| new_valid_i | input | 1 | Stream vector valid |
| new_ready_o | output | 1 | Block waits for a stream vector |
| mv_o | output | 512 | Sixteen resolved vectors, sub-block k at bits [32k+31:32k] |
| done_o | output | 1 | One-cycle pulse when all vectors are resolved |
| busy_o | output | 1 | Walk in progress |
| err_o | output | 1 | Illegal code seen in the last walk |

## Verification
The bench builds the block with its default parameters: a 4x4 grid and 16-bit components. This puts every grid position within reach, including all four column-0 and row-0 edge substitutions and every interior left/above copy. Negative components check that the sign bits are carried through untouched. The stream is run both back to back and with a gap before each vector, so the stall count and the cycle count can be compared exactly. The bench also runs an illegal-code walk that chains a zero vector into its neighbours, and it pokes start_i in the middle of a walk.

// File: rtl/mvr_pkg.sv
package mvr_pkg;
  typedef enum logic [1:0] {
    SB_LEFT  = 2'd0,
    SB_ABOVE = 2'd1,
    SB_NEW   = 2'd2,
    SB_BAD   = 2'd3
  } sb_code_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } walk_st_e;
endpackage

// File: rtl/mvr_ctrl.sv
module mvr_ctrl
  import mvr_pkg::*;
#(
  parameter int GRID = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [2*GRID*GRID-1:0]      codes_i,
  input  logic                        new_valid_i,
  output logic [$clog2(GRID*GRID)-1:0] idx_o,
  output sb_code_e                    code_o,
  output logic                        load_o,
  output logic                        wr_en_o,
  output logic                        new_ready_o,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        err_o
);
  localparam int N     = GRID * GRID;
  localparam int IDX_W = $clog2(N);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  walk_st_e          st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [2*N-1:0]    codes_q, codes_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  sb_code_e          cur;
  logic              step;

  assign cur  = sb_code_e'(codes_q[{idx_q, 1'b0} +: 2]);
  assign step = (st_q == ST_RUN) && ((cur != SB_NEW) || new_valid_i);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    codes_d = codes_q;
    done_d  = 1'b0;
    err_d   = err_q;
    load_o  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          st_d    = ST_RUN;
          idx_d   = '0;
          codes_d = codes_i;
          err_d   = 1'b0;
        end
      end
      ST_RUN: begin
        if (step) begin
          if (cur == SB_BAD) err_d = 1'b1;
          if (idx_q == LAST) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      codes_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (load_o) codes_q <= codes_d;
    end
  end

  assign idx_o       = idx_q;
  assign code_o      = cur;
  assign wr_en_o     = step;
  assign new_ready_o = (st_q == ST_RUN) && (cur == SB_NEW);
  assign busy_o      = (st_q == ST_RUN);
  assign done_o      = done_q;
  assign err_o       = err_q;

  // R2: raster order, one index per resolved sub-block
  p_raster_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && idx_q != LAST) |=> (idx_q == $past(idx_q) + IDX_W'(1)));
  // R5: a missing stream vector freezes the walk
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (new_ready_o && !new_valid_i) |=> ($stable(idx_q) && st_q == ST_RUN));
  // R7: error flag is sticky until the next accepted start
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !load_o) |=> err_q);
  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: captured codes cannot change during a walk
  p_codes_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> $stable(codes_q));
endmodule

// File: rtl/mvr_select.sv
module mvr_select
  import mvr_pkg::*;
#(
  parameter int GRID = 4,
  parameter int MV_W = 16
) (
  input  logic [$clog2(GRID*GRID)-1:0] idx_i,
  input  sb_code_e                     code_i,
  input  logic [GRID*GRID*2*MV_W-1:0]  mv_flat_i,
  input  logic [GRID*2*MV_W-1:0]       left_i,
  input  logic [GRID*2*MV_W-1:0]       top_i,
  input  logic [2*MV_W-1:0]            new_mv_i,
  output logic [2*MV_W-1:0]            res_o
);
  localparam int N     = GRID * GRID;
  localparam int VW    = 2 * MV_W;
  localparam int IDX_W = $clog2(N);
  localparam int CW    = $clog2(GRID);

  logic [VW-1:0]    mv_a   [N];
  logic [VW-1:0]    left_a [GRID];
  logic [VW-1:0]    top_a  [GRID];
  logic [CW-1:0]    row, col;

  for (genvar g = 0; g < N; g++) begin : g_mv
    assign mv_a[g] = mv_flat_i[g*VW +: VW];
  end
  for (genvar e = 0; e < GRID; e++) begin : g_edge
    assign left_a[e] = left_i[e*VW +: VW];
    assign top_a[e]  = top_i[e*VW +: VW];
  end

  assign row = idx_i[IDX_W-1:CW];
  assign col = idx_i[CW-1:0];

  always_comb begin
    case (code_i)
      SB_LEFT:  res_o = (col == '0) ? left_a[col == '0 ? row : row]
                                    : mv_a[idx_i - IDX_W'(1)];
      SB_ABOVE: res_o = (row == '0) ? top_a[col]
                                    : mv_a[idx_i - IDX_W'(GRID)];
      SB_NEW:   res_o = new_mv_i;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/mvr_store.sv
module mvr_store #(
  parameter int GRID = 4,
  parameter int MV_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_i,
  input  logic                         busy_i,
  input  logic [GRID*2*MV_W-1:0]       left_i,
  input  logic [GRID*2*MV_W-1:0]       top_i,
  input  logic                         wr_en_i,
  input  logic [$clog2(GRID*GRID)-1:0] wr_idx_i,
  input  logic [2*MV_W-1:0]            wr_data_i,
  output logic [GRID*GRID*2*MV_W-1:0]  mv_flat_o,
  output logic [GRID*2*MV_W-1:0]       left_q_o,
  output logic [GRID*2*MV_W-1:0]       top_q_o
);
  localparam int N  = GRID * GRID;
  localparam int VW = 2 * MV_W;

  logic [N*VW-1:0]    mv_q, mv_d;
  logic [GRID*VW-1:0] left_q, top_q;

  always_comb begin
    mv_d = mv_q;
    if (wr_en_i) mv_d[int'(wr_idx_i)*VW +: VW] = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_q   <= '0;
      left_q <= '0;
      top_q  <= '0;
    end else begin
      if (wr_en_i) mv_q <= mv_d;
      if (load_i) begin
        left_q <= left_i;
        top_q  <= top_i;
      end
    end
  end

  assign mv_flat_o = mv_q;
  assign left_q_o  = left_q;
  assign top_q_o   = top_q;

  // R8: results frozen while idle
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> $stable(mv_q));
  // R9: edge vectors frozen during a walk
  p_edge_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(left_q) && $stable(top_q)));
endmodule

// File: rtl/mv_split_resolver.sv
module mv_split_resolver
  import mvr_pkg::*;
#(
  parameter int GRID = 4,
  parameter int MV_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [2*GRID*GRID-1:0]      codes_i,
  input  logic [GRID*2*MV_W-1:0]      left_edge_i,
  input  logic [GRID*2*MV_W-1:0]      top_edge_i,
  input  logic [2*MV_W-1:0]           new_mv_i,
  input  logic                        new_valid_i,
  output logic                        new_ready_o,
  output logic [GRID*GRID*2*MV_W-1:0] mv_o,
  output logic                        done_o,
  output logic                        busy_o,
  output logic                        err_o
);
  localparam int N     = GRID * GRID;
  localparam int IDX_W = $clog2(N);
  localparam int VW    = 2 * MV_W;

  logic [IDX_W-1:0]   idx;
  sb_code_e           code;
  logic               load, wr_en, busy;
  logic [VW-1:0]      res;
  logic [N*VW-1:0]    mv_flat;
  logic [GRID*VW-1:0] left_q, top_q;

  mvr_ctrl #(.GRID(GRID)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .codes_i(codes_i),
    .new_valid_i(new_valid_i), .idx_o(idx), .code_o(code), .load_o(load),
    .wr_en_o(wr_en), .new_ready_o(new_ready_o), .busy_o(busy),
    .done_o(done_o), .err_o(err_o)
  );

  mvr_select #(.GRID(GRID), .MV_W(MV_W)) u_sel (
    .idx_i(idx), .code_i(code), .mv_flat_i(mv_flat), .left_i(left_q),
    .top_i(top_q), .new_mv_i(new_mv_i), .res_o(res)
  );

  mvr_store #(.GRID(GRID), .MV_W(MV_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load_i(load), .busy_i(busy),
    .left_i(left_edge_i), .top_i(top_edge_i), .wr_en_i(wr_en),
    .wr_idx_i(idx), .wr_data_i(res), .mv_flat_o(mv_flat),
    .left_q_o(left_q), .top_q_o(top_q)
  );

  assign mv_o   = mv_flat;
  assign busy_o = busy;
endmodule

// File: tb/test_mv_split_resolver.sv
`timescale 1ns/1ps
module test_mv_split_resolver;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [31:0]  codes_i = '0;
  logic [127:0] left_edge_i = '0;
  logic [127:0] top_edge_i = '0;
  logic [31:0]  new_mv_i = '0;
  logic         new_valid_i = 1'b0;
  logic         new_ready_o, done_o, busy_o, err_o;
  logic [511:0] mv_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0]  cfg_codes;
  logic [127:0] cfg_left, cfg_top;
  logic [31:0]  nvec [16];
  logic [31:0]  exp_mv [16];
  bit           exp_err;
  int           exp_new;

  always #5 clk = ~clk;

  mv_split_resolver i_mv_split_resolver (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .codes_i(codes_i),
    .left_edge_i(left_edge_i), .top_edge_i(top_edge_i), .new_mv_i(new_mv_i),
    .new_valid_i(new_valid_i), .new_ready_o(new_ready_o), .mv_o(mv_o),
    .done_o(done_o), .busy_o(busy_o), .err_o(err_o)
  );

  function automatic logic [31:0] mk(input int x, input int y);
    logic [15:0] xs, ys;
    xs = 16'(x);
    ys = 16'(y);
    return {ys, xs};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference resolution from the requirements
  task automatic model();
    int p;
    p = 0;
    exp_err = 0;
    for (int k = 0; k < 16; k++) begin
      int r, c;
      r = k / 4;
      c = k % 4;
      case (cfg_codes[2*k +: 2])
        2'd0: exp_mv[k] = (c == 0) ? cfg_left[32*r +: 32] : exp_mv[k-1];
        2'd1: exp_mv[k] = (r == 0) ? cfg_top[32*c +: 32] : exp_mv[k-4];
        2'd2: begin exp_mv[k] = nvec[p]; p++; end
        default: begin exp_mv[k] = '0; exp_err = 1; end
      endcase
    end
    exp_new = p;
  endtask

  task automatic set_code(input int k, input logic [1:0] c);
    cfg_codes[2*k +: 2] = c;
  endtask

  task automatic run_walk(input string name, input int gap, input bit poke);
    int cyc, p, stalls;
    bit hs;
    logic [511:0] snap;
    model();
    @(negedge clk);
    start_i = 1; codes_i = cfg_codes; left_edge_i = cfg_left; top_edge_i = cfg_top;
    @(negedge clk);
    start_i = 0; cyc = 0; p = 0; stalls = 0;
    chk(busy_o == 1'b1, "R2", {name, " busy after start"}, 64'(busy_o), 64'd1);
    forever begin
      new_valid_i = (gap == 0) || ((cyc % (gap + 1)) == gap);
      new_mv_i = nvec[p < 16 ? p : 0];
      if (poke && cyc == 5) begin
        start_i = 1; codes_i = ~cfg_codes; left_edge_i = ~cfg_left; top_edge_i = ~cfg_top;
      end
      #1;
      hs = new_ready_o && new_valid_i;
      if (new_ready_o && !new_valid_i) stalls++;
      @(negedge clk);
      start_i = 0;
      cyc++;
      if (hs) p++;
      if (done_o || cyc > 300) break;
    end
    new_valid_i = 0;
    chk(done_o == 1'b1, "R2", {name, " done seen"}, 64'(done_o), 64'd1);
    chk(cyc == 16 + stalls, "R5", {name, " walk length"}, 64'(cyc), 64'(16 + stalls));
    chk(p == exp_new, "R5", {name, " stream vectors consumed"}, 64'(p), 64'(exp_new));
    chk(err_o == exp_err, "R7", {name, " error flag"}, 64'(err_o), 64'(exp_err));
    for (int k = 0; k < 16; k++) begin
      string req;
      case (cfg_codes[2*k +: 2])
        2'd0: req = "R3";
        2'd1: req = "R4";
        2'd2: req = "R5";
        default: req = "R7";
      endcase
      chk(mv_o[32*k +: 32] === exp_mv[k], req,
          $sformatf("%s sub-block %0d (R6 layout)", name, k),
          64'(mv_o[32*k +: 32]), 64'(exp_mv[k]));
    end
    snap = mv_o;
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R8", {name, " done one cycle"},
        64'({done_o, busy_o}), 64'd0);
    repeat (3) @(negedge clk);
    chk(mv_o === snap, "R8", {name, " results held while idle"},
        64'(mv_o[63:0]), 64'(snap[63:0]));
  endtask

  task automatic t_reset();
    chk({busy_o, done_o, new_ready_o, err_o} == 4'b0, "R1", "reset outputs",
        64'({busy_o, done_o, new_ready_o, err_o}), 64'd0);
  endtask

  task automatic t_edges();
    for (int i = 0; i < 4; i++) begin
      cfg_left[32*i +: 32] = mk(10 + i, -20 - i);
      cfg_top[32*i +: 32]  = mk(-100 - i, 200 + i);
    end
  endtask

  task automatic t_all_left();
    t_edges();
    cfg_codes = '0;
    run_walk("all-left", 0, 0);
  endtask

  task automatic t_all_above();
    t_edges();
    for (int k = 0; k < 16; k++) set_code(k, 2'd1);
    run_walk("all-above", 0, 0);
  endtask

  task automatic t_partition();
    // rows: N L L N / A A L A / N L A A / A L A L
    logic [1:0] pat [16] = '{2,0,0,2, 1,1,0,1, 2,0,1,1, 1,0,1,0};
    t_edges();
    for (int k = 0; k < 16; k++) begin
      set_code(k, pat[k]);
      nvec[k] = mk(-3000 + 7 * k, 1234 - 11 * k);
    end
    run_walk("partition-stall", 1, 0);
    run_walk("partition-fast", 0, 0);
  endtask

  task automatic t_all_new();
    for (int k = 0; k < 16; k++) begin
      set_code(k, 2'd2);
      nvec[k] = mk(-32768 + k, 32767 - k);
    end
    run_walk("all-new-gap2", 2, 0);
  endtask

  task automatic t_illegal();
    t_edges();
    cfg_codes = '0;
    set_code(0, 2'd3);
    set_code(1, 2'd0);
    set_code(5, 2'd1);
    set_code(10, 2'd3);
    set_code(11, 2'd2);
    nvec[0] = mk(-1, -1);
    run_walk("illegal", 0, 0);
    cfg_codes = '0;
    run_walk("clean-after-illegal", 0, 0);
  endtask

  task automatic t_start_busy();
    t_edges();
    for (int k = 0; k < 16; k++) begin
      set_code(k, (k % 3 == 0) ? 2'd2 : 2'(k % 2));
      nvec[k] = mk(k * 100 - 500, -k);
    end
    run_walk("start-while-busy R9", 0, 1);
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) nvec[k] = '0;
    cfg_codes = '0; cfg_left = '0; cfg_top = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_left();
    t_all_above();
    t_partition();
    t_all_new();
    t_illegal();
    t_start_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule